// File: doc/BRIEF.md
# Flash Status and ID Responder

This block sits beside the command decoder of a NAND-style flash device model and produces the byte that the I/O bus shows when the host reads status or the identification codes. It keeps the pass/fail bit of the last program or erase. It builds a status byte from that bit, the live busy flag and the write-protect pin. It plays out a fixed two-byte identification sequence. It also tells the bus multiplexer which source to drive: the array data path, the status byte or the ID byte.

Command events arrive as single-cycle pulses with their code. Falling edges of the read strobe and of chip enable arrive as single-cycle pulses that were already synchronised. Once status mode is entered, it stays in force through any number of read strobes, including after the device has gone ready. It ends only when a read command or a reset arrives. The block also holds the array column pointer. Strobes taken while status or ID is shown do not move that pointer, so array reading continues where it stopped when the read command returns the bus to the array.

Top module: `flash_status_id`

## Requirements
- R1: The status byte is {wp_n_i, ready, 5'b00000, fail}: bit 7 is 1 when writes are allowed, bit 6 is 1 when not busy, bit 0 is 1 when the last program/erase failed, and bits 5..1 are always 0.
- R2: A res_valid_i pulse stores res_fail_i as the fail bit. Command FFh clears the fail bit, and it wins over a result pulse in the same cycle.
- R3: After command 70h, data_o is 00h until the first read-strobe or chip-enable fall that arrives without a command in its cycle. From the following cycle on, the status byte is shown.
- R4: Once shown, the status byte follows busy_i and wp_n_i in the same cycle, without further strobes, for as long as status mode lasts.
- R5: Command FFh returns sel_o to array. With wp_n_i high and busy_i low, a later status read returns C0h.
- R6: After command 90h, data_o is 00h. Once an address cycle of 00h has been taken, successive read strobes give 04h, then E6h, then E6h again for every further strobe. An address other than 00h leaves the byte at 00h.
- R7: sel_o encodes 0 = array, 1 = status, 2 = ID. Command 70h selects status, 90h selects ID, 00h and FFh select array, and any other code is ignored. In array mode data_o is 00h.
- R8: In array mode each read strobe advances col_o by one. After column NUM_COLS-1 (527 by default) it wraps to 0.
- R9: While status or ID is selected, col_o holds. Command 00h returns to array mode without changing col_o, and the next strobe continues from the held column.
- R10: A read strobe that falls in the same cycle as a command has no effect: the column does not advance and status is not shown.
- R11: After reset sel_o is array, col_o is 0, data_o is 00h and the fail bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command cycle pulse |
| cmd_i | input | 8 | Command code |
| addr_valid_i | input | 1 | Address cycle pulse |
| addr_i | input | 8 | Address byte |
| rd_fall_i | input | 1 | Read-strobe falling-edge pulse |
| ce_fall_i | input | 1 | Chip-enable falling-edge pulse |
| busy_i | input | 1 | Internal operation in progress |
| wp_n_i | input | 1 | Write-protect pin, high = writes allowed |
| res_valid_i | input | 1 | Program/erase result pulse |
| res_fail_i | input | 1 | Result of that operation, 1 = fail |
| data_o | output | 8 | Status or ID byte |
| sel_o | output | 2 | Bus source: 0 array, 1 status, 2 ID |
| col_o | output | COL_W (10) | Array column pointer |

## Verification
Two pairs of functions can fall in the same cycle: a reset command with an arriving program/erase result, and a command with a read strobe. The bench provokes both as directed cases. It also produces them often in a long random run with a fixed seed. In every cycle it compares the fail bit that the status byte reveals, the column and the selected source against a bench model in which the command always takes precedence.

// File: rtl/flash_resp_pkg.sv
package flash_resp_pkg;

    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_ID     = 2'd2
    } sel_e;

    localparam logic [7:0] OP_READ   = 8'h00;
    localparam logic [7:0] OP_STATUS = 8'h70;
    localparam logic [7:0] OP_IDENT  = 8'h90;
    localparam logic [7:0] OP_RESET  = 8'hFF;

    typedef struct packed {
        logic       wr_open;
        logic       ready;
        logic [4:0] spare;
        logic       fail;
    } status_t;

    typedef struct packed {
        logic go_status;
        logic go_ident;
        logic go_array;
        logic clr_fail;
    } cmd_dec_t;

    function automatic status_t make_status(input logic wp_n, input logic busy,
                                            input logic fail);
        status_t s;
        s.wr_open = wp_n;
        s.ready   = ~busy;
        s.spare   = '0;
        s.fail    = fail;
        return s;
    endfunction

    function automatic cmd_dec_t decode(input logic vld, input logic [7:0] code);
        cmd_dec_t d;
        d.go_status = vld && (code == OP_STATUS);
        d.go_ident  = vld && (code == OP_IDENT);
        d.go_array  = vld && ((code == OP_READ) || (code == OP_RESET));
        d.clr_fail  = vld && (code == OP_RESET);
        return d;
    endfunction

endpackage

// File: rtl/flash_status_reg.sv
module flash_status_reg
    import flash_resp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr_i,
    input  logic    res_valid_i,
    input  logic    res_fail_i,
    input  logic    busy_i,
    input  logic    wp_n_i,
    output status_t status_o
);
    logic fail_q;

    always_ff @(posedge clk) begin
        if (rst)              fail_q <= 1'b0;
        else if (clr_i)       fail_q <= 1'b0;
        else if (res_valid_i) fail_q <= res_fail_i;
    end

    assign status_o = make_status(wp_n_i, busy_i, fail_q);
endmodule

// File: rtl/flash_id_seq.sv
module flash_id_seq #(
    parameter logic [7:0] FIRST_CODE  = 8'h04,
    parameter logic [7:0] SECOND_CODE = 8'hE6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       addr_hit_i,
    input  logic       strobe_i,
    output logic [7:0] byte_o
);
    logic       armed_q;
    logic       second_q;
    logic [7:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            armed_q  <= 1'b0;
            second_q <= 1'b0;
            byte_q   <= 8'h00;
        end else begin
            if (addr_hit_i) armed_q <= 1'b1;
            if (strobe_i && armed_q) begin
                byte_q   <= second_q ? SECOND_CODE : FIRST_CODE;
                second_q <= 1'b1;
            end
        end
    end

    assign byte_o = byte_q;
endmodule

// File: rtl/flash_col_ctr.sv
module flash_col_ctr #(
    parameter int NUM_COLS = 528,
    localparam int COL_W   = $clog2(NUM_COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    output logic [COL_W-1:0] col_o
);
    localparam logic [COL_W-1:0] LAST = COL_W'(NUM_COLS - 1);
    logic [COL_W-1:0] col_q;

    always_ff @(posedge clk) begin
        if (rst)         col_q <= '0;
        else if (step_i) col_q <= (col_q == LAST) ? '0 : col_q + 1'b1;
    end

    assign col_o = col_q;
endmodule

// File: rtl/flash_status_id.sv
module flash_status_id
    import flash_resp_pkg::*;
#(
    parameter int         NUM_COLS  = 528,
    parameter logic [7:0] MAKER_ID  = 8'h04,
    parameter logic [7:0] DEVICE_ID = 8'hE6,
    localparam int        COL_W     = $clog2(NUM_COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid_i,
    input  logic [7:0]       cmd_i,
    input  logic             addr_valid_i,
    input  logic [7:0]       addr_i,
    input  logic             rd_fall_i,
    input  logic             ce_fall_i,
    input  logic             busy_i,
    input  logic             wp_n_i,
    input  logic             res_valid_i,
    input  logic             res_fail_i,
    output logic [7:0]       data_o,
    output logic [1:0]       sel_o,
    output logic [COL_W-1:0] col_o
);
    cmd_dec_t   dec;
    sel_e       sel_q;
    logic       shown_q;
    logic       quiet;
    status_t    status;
    logic [7:0] id_byte;

    assign dec   = decode(cmd_valid_i, cmd_i);
    assign quiet = ~cmd_valid_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= SEL_ARRAY;
            shown_q <= 1'b0;
        end else if (dec.go_status) begin
            sel_q   <= SEL_STATUS;
            shown_q <= 1'b0;
        end else if (dec.go_ident) begin
            sel_q   <= SEL_ID;
        end else if (dec.go_array) begin
            sel_q   <= SEL_ARRAY;
        end else if (quiet && sel_q == SEL_STATUS && (rd_fall_i || ce_fall_i)) begin
            shown_q <= 1'b1;
        end
    end

    flash_status_reg u_stat (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (dec.clr_fail),
        .res_valid_i (res_valid_i),
        .res_fail_i  (res_fail_i),
        .busy_i      (busy_i),
        .wp_n_i      (wp_n_i),
        .status_o    (status)
    );

    flash_id_seq #(
        .FIRST_CODE  (MAKER_ID),
        .SECOND_CODE (DEVICE_ID)
    ) u_id (
        .clk        (clk),
        .rst        (rst),
        .start_i    (dec.go_ident),
        .addr_hit_i (quiet && sel_q == SEL_ID && addr_valid_i && addr_i == 8'h00),
        .strobe_i   (quiet && sel_q == SEL_ID && rd_fall_i),
        .byte_o     (id_byte)
    );

    flash_col_ctr #(.NUM_COLS(NUM_COLS)) u_col (
        .clk    (clk),
        .rst    (rst),
        .step_i (quiet && sel_q == SEL_ARRAY && rd_fall_i),
        .col_o  (col_o)
    );

    always_comb begin
        unique case (sel_q)
            SEL_STATUS: data_o = shown_q ? status : 8'h00;
            SEL_ID:     data_o = id_byte;
            default:    data_o = 8'h00;
        endcase
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/flash_status_id_chk.sv
module flash_status_id_chk #(
    parameter int  NUM_COLS = 528,
    localparam int COL_W    = $clog2(NUM_COLS)
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid_i,
    input logic [7:0]       cmd_i,
    input logic             rd_fall_i,
    input logic             ce_fall_i,
    input logic             busy_i,
    input logic             wp_n_i,
    input logic [7:0]       data_o,
    input logic [1:0]       sel_o,
    input logic [COL_W-1:0] col_o
);
    localparam logic [COL_W-1:0] LAST = COL_W'(NUM_COLS - 1);

    a_r1_spare_zero: assert property (@(posedge clk) disable iff (rst)
        (sel_o == 2'd1) |-> (data_o[5:1] == 5'b0));

    a_r3_hidden_after_cmd: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && cmd_i == 8'h70) |=> (data_o == 8'h00 && sel_o == 2'd1));

    a_r3_shown_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (sel_o == 2'd1 && !cmd_valid_i && (rd_fall_i || ce_fall_i)) |=> (busy_i || data_o[6]));

    a_r4_live_track: assert property (@(posedge clk) disable iff (rst)
        (sel_o == 2'd1 && data_o != 8'h00) |-> (data_o[7] == wp_n_i && data_o[6] == !busy_i));

    a_r6_id_values: assert property (@(posedge clk) disable iff (rst)
        (sel_o == 2'd2) |-> (data_o == 8'h00 || data_o == 8'h04 || data_o == 8'hE6));

    a_r7_sel_legal: assert property (@(posedge clk) disable iff (rst)
        sel_o != 2'd3);

    a_r8_col_step: assert property (@(posedge clk) disable iff (rst)
        (sel_o == 2'd0 && rd_fall_i && !cmd_valid_i) |=>
        (col_o == (($past(col_o) == LAST) ? '0 : $past(col_o) + 1'b1)));

    a_r9_col_hold: assert property (@(posedge clk) disable iff (rst)
        (sel_o != 2'd0) |=> $stable(col_o));

    a_r10_cmd_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && rd_fall_i) |=> $stable(col_o));
endmodule

bind flash_status_id flash_status_id_chk #(.NUM_COLS(NUM_COLS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .rd_fall_i   (rd_fall_i),
    .ce_fall_i   (ce_fall_i),
    .busy_i      (busy_i),
    .wp_n_i      (wp_n_i),
    .data_o      (data_o),
    .sel_o       (sel_o),
    .col_o       (col_o)
);

// File: tb/flash_status_id_tb.sv
`timescale 1ns/1ps
module flash_status_id_tb_top;
    localparam int NUM_COLS = 528;
    localparam int COL_W    = $clog2(NUM_COLS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 0, addr_valid = 0, rd_fall = 0, ce_fall = 0;
    logic res_valid = 0, res_fail = 0, busy = 0, wp_n = 1;
    logic [7:0] cmd = 0, addr = 0;
    logic [7:0] data;
    logic [1:0] sel;
    logic [COL_W-1:0] col;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    int m_sel = 0, m_col = 0, m_idx = 0;
    bit m_shown = 0, m_fail = 0, m_armed = 0;
    logic [7:0] m_id = 0;

    always #2.5 clk = ~clk;

    flash_status_id dut_i (
        .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
        .addr_valid_i(addr_valid), .addr_i(addr), .rd_fall_i(rd_fall),
        .ce_fall_i(ce_fall), .busy_i(busy), .wp_n_i(wp_n),
        .res_valid_i(res_valid), .res_fail_i(res_fail),
        .data_o(data), .sel_o(sel), .col_o(col)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_data();
        if (m_sel == 1) return m_shown ? {wp_n, ~busy, 5'b0, m_fail} : 8'h00;
        if (m_sel == 2) return m_id;
        return 8'h00;
    endfunction

    task automatic model_step();
        if (cmd_valid && cmd == 8'hFF) m_fail = 0;
        else if (res_valid)            m_fail = res_fail;
        if (cmd_valid) begin
            case (cmd)
                8'h70: begin m_sel = 1; m_shown = 0; end
                8'h90: begin m_sel = 2; m_armed = 0; m_idx = 0; m_id = 8'h00; end
                8'h00, 8'hFF: m_sel = 0;
                default: ;
            endcase
        end else begin
            if (m_sel == 1 && (rd_fall || ce_fall)) m_shown = 1;
            if (m_sel == 2 && rd_fall && m_armed) begin
                m_id  = (m_idx == 0) ? 8'h04 : 8'hE6;
                m_idx = 1;
            end
            if (m_sel == 2 && addr_valid && addr == 8'h00) m_armed = 1;
            if (m_sel == 0 && rd_fall) m_col = (m_col == NUM_COLS - 1) ? 0 : m_col + 1;
        end
    endtask

    // drive one cycle of pulses, then check against the model at the negedge
    task automatic cyc(input bit cv, input logic [7:0] c, input bit av, input logic [7:0] a,
                       input bit rd, input bit ce, input bit rv, input bit rf);
        cmd_valid = cv; cmd = c; addr_valid = av; addr = a;
        rd_fall = rd; ce_fall = ce; res_valid = rv; res_fail = rf;
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmd_valid = 0; addr_valid = 0; rd_fall = 0; ce_fall = 0; res_valid = 0;
        check("R7 sel", sel, m_sel);
        check(m_sel == 2 ? "R6 data" : "R1 data", data, exp_data());
        check("R8 col", col, m_col);
    endtask

    task automatic idle();     cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic cmd_only(input logic [7:0] c); cyc(1, c, 0, 0, 0, 0, 0, 0); endtask
    task automatic strobe();   cyc(0, 0, 0, 0, 1, 0, 0, 0); endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        check("R11 sel", sel, 0);
        check("R11 col", col, 0);
        check("R11 data", data, 0);

        // R8 array strobes
        repeat (3) strobe();
        check("R8 col after 3", col, 3);

        // R3 status hidden then shown, R1 layout, R4 live
        busy = 1; wp_n = 1;
        cmd_only(8'h70);
        check("R3 hidden", data, 8'h00);
        check("R7 status sel", sel, 1);
        strobe();
        check("R1 busy status", data, 8'h80);
        busy = 0; #0.1;
        check("R4 live ready", data, 8'hC0);
        repeat (4) strobe();
        check("R9 col held", col, 3);
        cmd_only(8'h00);
        check("R9 back to array", sel, 0);
        strobe();
        check("R9 resume column", col, 4);

        // R2 fail capture, R3 via chip enable
        cyc(0, 0, 0, 0, 0, 0, 1, 1);
        cmd_only(8'h70);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        check("R2 fail shown", data, 8'hC1);
        wp_n = 0; #0.1;
        check("R4 wp live", data, 8'h41);
        wp_n = 1;

        // R2/R5 reset wins over same-cycle fail result
        cyc(1, 8'hFF, 0, 0, 0, 0, 1, 1);
        check("R5 sel array", sel, 0);
        cmd_only(8'h70);
        strobe();
        check("R5 C0 after reset", data, 8'hC0);

        // R6 ID sequence
        cmd_only(8'h90);
        check("R6 sel id", sel, 2);
        strobe();
        check("R6 before addr", data, 8'h00);
        cyc(0, 0, 1, 8'h00, 0, 0, 0, 0);
        strobe();
        check("R6 first code", data, 8'h04);
        strobe();
        check("R6 second code", data, 8'hE6);
        strobe();
        check("R6 repeat", data, 8'hE6);
        cmd_only(8'h90);
        cyc(0, 0, 1, 8'h05, 0, 0, 0, 0);
        strobe();
        check("R6 bad addr", data, 8'h00);
        cmd_only(8'h55);
        check("R7 unknown ignored", sel, 2);

        // R8 wrap
        cmd_only(8'h00);
        check("R9 col kept", col, 4);
        while (col != COL_W'(NUM_COLS - 1)) strobe();
        strobe();
        check("R8 wrap", col, 0);

        // R10 command and strobe together
        strobe();
        cyc(1, 8'h70, 0, 0, 1, 0, 0, 0);
        check("R10 col not stepped", col, 1);
        check("R10 not shown", data, 8'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit cv, av, rd, ce, rv, rf;
            logic [7:0] c, a;
            int pick;
            cv = ($urandom % 8) == 0;
            pick = $urandom % 5;
            c = (pick == 0) ? 8'h70 : (pick == 1) ? 8'h90 : (pick == 2) ? 8'h00 :
                (pick == 3) ? 8'hFF : 8'h3C;
            av = ($urandom % 6) == 0;
            a  = (($urandom % 2) == 0) ? 8'h00 : 8'($urandom % 256);
            rd = ($urandom % 2) == 0;
            ce = ($urandom % 8) == 0;
            rv = ($urandom % 16) == 0;
            rf = ($urandom % 2) == 0;
            if (($urandom % 16) == 0) busy = ~busy;
            if (($urandom % 32) == 0) wp_n = ~wp_n;
            cyc(cv, c, av, a, rd, ce, rv, rf);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule